// File: doc/BRIEF.md
# I2C Register Target with Looping Address Pointer

This block is an I2C target that fronts a small register bank. It samples the open-drain SCL and SDA lines with the system clock and finds START, repeated START and STOP on the bus. It answers to one fixed 7-bit address and acknowledges the bytes it receives. In a write transaction, the first data byte loads an internal register pointer. Each later byte is written to the register that the pointer selects. In a read transaction, bytes are sent from the pointer onward.

After every byte the pointer advances by an unusual rule. From 9 it returns to 3. From the top address or anything above it, it returns to 0. In every other case it adds one. A burst read started on the data registers therefore keeps cycling through them. Registers 3 to 8 are read-only and show a parallel input. The other registers are writable, but only in the bits that a per-register mask allows. Addresses with no register read as zero, and writes to them are discarded. The block drives the bus only through an SDA pull-low output, and the whole bank is available as a flat parallel output.

Top module: `i2c_regbank_target`

## Requirements
- R1: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A START with no STOP before it (a repeated START) restarts address decoding, and the pointer value carries across it.
- R2: The target answers only the address byte 0x3C (write) or 0x3D (read): address 7'b0011110 in bits 7..1, and the direction in bit 0, where 1 means read. Any other address byte gets a NACK, and the rest of that transaction is not acknowledged and changes nothing.
- R3: Bytes travel MSB first. During the 9th clock, the target pulls SDA low to acknowledge the address byte and every byte written to it.
- R4: In a write, the first data byte loads the pointer. Each later byte is written to the register at the pointer.
- R5: After each data byte written or read, the pointer changes as follows: 9 becomes 3, any value of 12 or more becomes 0, and every other value increases by 1.
- R6: Reading an address of 13 or more returns 0x00. Writing to such an address changes no register.
- R7: Writable bit masks are reg0 0xFF, reg1 0xE0, reg2 0x03, reg9 0xFF, reg10 0x0F, reg11 0xF0 and reg12 0xFF. Bits outside a mask keep their value. Registers 3..8 read byte k of the read-only input (bits 8k+7..8k, with k = address - 3) and ignore writes.
- R8: In a read, a NACK from the master ends transmission. SDA stays released until the next START or STOP, and the pointer has already moved past the last byte sent.
- R9: The SDA pull-low output changes only while SCL is low.
- R10: STOP returns the target to idle but keeps the pointer. A later read without a pointer write continues where the last one stopped.
- R11: After reset, SDA is released, every writable register is 0x00, and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| ro_data_i | input | 48 | Contents of read-only registers 3..8, byte k holds address 3+k |
| sda_pull_o | output | 1 | 1 pulls the SDA line low |
| bank_o | output | 104 | All 13 registers, byte i holds address i |

## Verification
The bench uses the default parameters: 13 registers, a loop from 9 back to 3, read-only registers 3..8, the seven writable masks and two synchronizer stages. One bus bit lasts four quarter phases of six system clocks each. With these values, random pointers from 0 to 15 reach both wrap branches, the read-only window and the invalid range within a few bytes. Directed cases add pointer loads at 9, 12 and 0x20, a read past the top address, a wrong address, a master NACK followed by extra clocks, and a read resumed after STOP.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WBYTE,
        ST_WACK,
        ST_RBYTE,
        ST_RACK,
        ST_SKIP
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e st;
        logic [2:0] cnt;
        logic [7:0] sh;
        logic [7:0] ptr;
        logic       ptr_set;
        logic       rnw;
        logic       half;
        logic       pull;
    } tgt_regs_t;

    function automatic logic [7:0] ptr_step(input logic [7:0] cur,
                                            input logic [7:0] loop_from,
                                            input logic [7:0] loop_to,
                                            input logic [7:0] top);
        if (cur == loop_from) begin
            return loop_to;
        end else if (cur >= top) begin
            return 8'h00;
        end
        return cur + 8'd1;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int W = STAGES + 1;

    typedef struct packed {
        logic [W-1:0] scl;
        logic [W-1:0] sda;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  scl_prev, sda_prev;

    always_comb begin
        sync_d     = sync_q;
        sync_d.scl = {sync_q.scl[W-2:0], scl_i};
        sync_d.sda = {sync_q.sda[W-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign scl_o    = sync_q.scl[W-2];
    assign sda_o    = sync_q.sda[W-2];
    assign scl_prev = sync_q.scl[W-1];
    assign sda_prev = sync_q.sda[W-1];

    assign scl_rise_o = scl_o & ~scl_prev;
    assign scl_fall_o = ~scl_o & scl_prev;
    assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
    assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;

endmodule

// File: rtl/i2c_regfile.sv
module i2c_regfile #(
    parameter int                    NUM_REGS = 13,
    parameter int                    RO_FIRST = 3,
    parameter int                    RO_LAST  = 8,
    parameter logic [NUM_REGS*8-1:0] WR_MASK  = '1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [7:0]                        wr_addr,
    input  logic [7:0]                        wr_data,
    input  logic [7:0]                        rd_addr,
    output logic [7:0]                        rd_data,
    input  logic [(RO_LAST-RO_FIRST+1)*8-1:0] ro_data_i,
    output logic [NUM_REGS*8-1:0]             bank_o
);
    localparam logic [7:0] NREG8 = 8'(NUM_REGS);
    localparam logic [7:0] ROF8  = 8'(RO_FIRST);
    localparam logic [7:0] ROL8  = 8'(RO_LAST);

    logic [NUM_REGS-1:0][7:0] store_d, store_q;
    logic [NUM_REGS-1:0][7:0] bank;

    always_comb begin
        store_d = store_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en && wr_addr == 8'(i) && !(i >= RO_FIRST && i <= RO_LAST)) begin
                store_d[i] = (wr_data & WR_MASK[i*8 +: 8])
                           | (store_q[i] & ~WR_MASK[i*8 +: 8]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            store_q <= store_d;
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (g >= RO_FIRST && g <= RO_LAST) begin : g_ro
            assign bank[g] = ro_data_i[(g-RO_FIRST)*8 +: 8];
        end else begin : g_rw
            assign bank[g] = store_q[g];
        end
    end

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == 8'(i)) begin
                rd_data = bank[i];
            end
        end
    end

    assign bank_o = bank;

    // R6: a write outside the register range leaves every register as it was
    a_r6_invalid_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= NREG8) |=> $stable(store_q));

    // R7: a write to a read-only register leaves every register as it was
    a_r7_ro_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= ROF8 && wr_addr <= ROL8) |=> $stable(store_q));

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'b0011110,
    parameter logic [7:0] LOOP_FROM   = 8'd9,
    parameter logic [7:0] LOOP_TO     = 8'd3,
    parameter logic [7:0] PTR_TOP     = 8'd12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_evt,
    input  logic       stop_evt,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic [7:0] rd_addr,
    input  logic [7:0] rd_data,
    output logic       sda_pull_o
);
    tgt_regs_t  q, n;
    logic [7:0] rx_byte;
    logic       ptr_load;

    assign rx_byte = {q.sh[6:0], sda_s};

    always_comb begin
        n        = q;
        wr_en    = 1'b0;
        wr_addr  = q.ptr;
        wr_data  = rx_byte;
        rd_addr  = q.ptr;
        ptr_load = 1'b0;
        if (start_evt) begin
            n.st      = ST_ADDR;
            n.cnt     = 3'd0;
            n.pull    = 1'b0;
            n.half    = 1'b0;
            n.ptr_set = 1'b0;
        end else if (stop_evt) begin
            n.st   = ST_IDLE;
            n.pull = 1'b0;
            n.half = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        n.sh  = rx_byte;
                        n.cnt = q.cnt + 3'd1;
                        if (q.cnt == 3'd7) begin
                            if (rx_byte[7:1] == TARGET_ADDR) begin
                                n.st   = ST_AACK;
                                n.rnw  = rx_byte[0];
                                n.half = 1'b0;
                            end else begin
                                n.st = ST_SKIP;
                            end
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        if (!q.half) begin
                            n.pull = 1'b1;
                            n.half = 1'b1;
                        end else begin
                            n.half = 1'b0;
                            n.cnt  = 3'd0;
                            if (q.rnw) begin
                                n.st   = ST_RBYTE;
                                n.sh   = rd_data;
                                n.pull = ~rd_data[7];
                                n.ptr  = ptr_step(q.ptr, LOOP_FROM, LOOP_TO, PTR_TOP);
                            end else begin
                                n.st   = ST_WBYTE;
                                n.pull = 1'b0;
                            end
                        end
                    end
                end
                ST_WBYTE: begin
                    if (scl_rise) begin
                        n.sh  = rx_byte;
                        n.cnt = q.cnt + 3'd1;
                        if (q.cnt == 3'd7) begin
                            n.st   = ST_WACK;
                            n.half = 1'b0;
                            if (!q.ptr_set) begin
                                n.ptr     = rx_byte;
                                n.ptr_set = 1'b1;
                                ptr_load  = 1'b1;
                            end else begin
                                wr_en = 1'b1;
                                n.ptr = ptr_step(q.ptr, LOOP_FROM, LOOP_TO, PTR_TOP);
                            end
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        if (!q.half) begin
                            n.pull = 1'b1;
                            n.half = 1'b1;
                        end else begin
                            n.pull = 1'b0;
                            n.half = 1'b0;
                            n.cnt  = 3'd0;
                            n.st   = ST_WBYTE;
                        end
                    end
                end
                ST_RBYTE: begin
                    if (scl_fall) begin
                        n.cnt = q.cnt + 3'd1;
                        if (q.cnt == 3'd7) begin
                            n.pull = 1'b0;
                            n.half = 1'b0;
                            n.st   = ST_RACK;
                        end else begin
                            n.sh   = {q.sh[6:0], 1'b0};
                            n.pull = ~q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        n.half = sda_s;
                    end else if (scl_fall) begin
                        n.half = 1'b0;
                        if (!q.half) begin
                            n.st   = ST_RBYTE;
                            n.cnt  = 3'd0;
                            n.sh   = rd_data;
                            n.pull = ~rd_data[7];
                            n.ptr  = ptr_step(q.ptr, LOOP_FROM, LOOP_TO, PTR_TOP);
                        end else begin
                            n.st   = ST_SKIP;
                            n.pull = 1'b0;
                        end
                    end
                end
                default: begin
                    n.pull = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= ST_IDLE;
            q.cnt     <= 3'd0;
            q.sh      <= 8'h00;
            q.ptr     <= 8'h00;
            q.ptr_set <= 1'b0;
            q.rnw     <= 1'b0;
            q.half    <= 1'b0;
            q.pull    <= 1'b0;
        end else begin
            q <= n;
        end
    end

    assign sda_pull_o = q.pull;

    // R9: the pull-low output holds still while SCL stays high
    a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_evt) && !$past(stop_evt))
        |-> $stable(q.pull));

    // R2: once the address is rejected the line is never pulled
    a_r2_skip_released: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SKIP) |-> !q.pull);

    // R5: an automatic step away from the loop point lands on the loop target
    a_r5_loop_back: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.ptr) == LOOP_FROM && !$stable(q.ptr) && !$past(ptr_load))
        |-> q.ptr == LOOP_TO);

    // R5: an automatic step from the top or above lands on zero
    a_r5_top_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.ptr) >= PTR_TOP && !$stable(q.ptr) && !$past(ptr_load))
        |-> q.ptr == 8'h00);

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target #(
    parameter logic [6:0]            TARGET_ADDR = 7'b0011110,
    parameter int                    NUM_REGS    = 13,
    parameter int                    RO_FIRST    = 3,
    parameter int                    RO_LAST     = 8,
    parameter int                    LOOP_FROM   = 9,
    parameter int                    LOOP_TO     = 3,
    parameter int                    SYNC_STAGES = 2,
    parameter logic [NUM_REGS*8-1:0] WR_MASK     =
        104'hFF_F0_0F_FF_00_00_00_00_00_00_03_E0_FF
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              scl_i,
    input  logic                              sda_i,
    input  logic [(RO_LAST-RO_FIRST+1)*8-1:0] ro_data_i,
    output logic                              sda_pull_o,
    output logic [NUM_REGS*8-1:0]             bank_o
);
    localparam logic [7:0] PTR_TOP = 8'(NUM_REGS - 1);
    localparam logic [7:0] LFROM8  = 8'(LOOP_FROM);
    localparam logic [7:0] LTO8    = 8'(LOOP_TO);

    logic       scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic       wr_en;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;

    i2c_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_evt),
        .stop_o     (stop_evt)
    );

    i2c_target_fsm #(
        .TARGET_ADDR (TARGET_ADDR),
        .LOOP_FROM   (LFROM8),
        .LOOP_TO     (LTO8),
        .PTR_TOP     (PTR_TOP)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_evt  (start_evt),
        .stop_evt   (stop_evt),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .sda_pull_o (sda_pull_o)
    );

    i2c_regfile #(
        .NUM_REGS (NUM_REGS),
        .RO_FIRST (RO_FIRST),
        .RO_LAST  (RO_LAST),
        .WR_MASK  (WR_MASK)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .ro_data_i (ro_data_i),
        .bank_o    (bank_o)
    );

endmodule

// File: tb/i2c_regbank_target_tb.sv
module i2c_regbank_target_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam int NREG       = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic [47:0] ro_data = '0;
    logic        sda_pull;
    logic [103:0] bank;
    logic        sda_line;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 0;
    int r9_viol  = 0;

    logic [7:0] model_reg [NREG];
    logic [7:0] model_ptr;
    logic [7:0] wbuf [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;

    i2c_regbank_target u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .ro_data_i  (ro_data),
        .sda_pull_o (sda_pull),
        .bank_o     (bank)
    );

    // R9 monitor: pull-low must not change while SCL is high
    logic prev_scl = 1'b1, prev_pull = 1'b0;
    always @(negedge clk) begin
        if (rst_n && m_scl && prev_scl && sda_pull != prev_pull) r9_viol++;
        prev_scl  <= m_scl;
        prev_pull <= sda_pull;
    end

    function automatic logic [7:0] mask_of(input int i);
        case (i)
            0: return 8'hFF; 1: return 8'hE0; 2: return 8'h03;
            9: return 8'hFF; 10: return 8'h0F; 11: return 8'hF0; 12: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit is_ro(input int i);
        return (i >= 3 && i <= 8);
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] p);
        if (p >= 8'(NREG)) return 8'h00;
        if (is_ro(int'(p))) return ro_data[(int'(p)-3)*8 +: 8];
        return model_reg[p];
    endfunction

    function automatic logic [7:0] exp_next(input logic [7:0] p);
        if (p == 8'd9) return 8'd3;
        if (p >= 8'd12) return 8'd0;
        return p + 8'd1;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b;    tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~give_ack);
    endtask

    task automatic check_bank(input string req);
        for (int i = 0; i < NREG; i++) begin
            check(req, $sformatf("bank reg %0d", i), 32'(bank[i*8 +: 8]),
                  32'(exp_read(8'(i))));
        end
    endtask

    // write transaction: pointer byte then n data bytes from wbuf
    task automatic do_write(input string req, input logic [7:0] ptr, input int n);
        logic ack;
        bus_start();
        send_byte(8'h3C, ack);
        check("R2", "write address ack", 32'(ack), 32'd1);
        send_byte(ptr, ack);
        check("R3", "pointer byte ack", 32'(ack), 32'd1);
        model_ptr = ptr;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack);
            check("R3", "data byte ack", 32'(ack), 32'd1);
            if (model_ptr < 8'(NREG) && !is_ro(int'(model_ptr))) begin
                model_reg[model_ptr] = (wbuf[i] & mask_of(int'(model_ptr)))
                                     | (model_reg[model_ptr] & ~mask_of(int'(model_ptr)));
            end
            model_ptr = exp_next(model_ptr);
        end
        bus_stop();
        tick(4);
        check_bank(req);
    endtask

    // read transaction, optional pointer set followed by a repeated START
    task automatic do_read(input string req, input bit set_ptr,
                           input logic [7:0] ptr, input int n);
        logic ack;
        logic [7:0] v;
        bus_start();
        if (set_ptr) begin
            send_byte(8'h3C, ack);
            check("R2", "write address ack", 32'(ack), 32'd1);
            send_byte(ptr, ack);
            check("R4", "pointer byte ack", 32'(ack), 32'd1);
            model_ptr = ptr;
            bus_start();
        end
        send_byte(8'h3D, ack);
        check("R1", "read address ack after START", 32'(ack), 32'd1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, v);
            check(req, $sformatf("read byte at ptr %0h", model_ptr),
                  32'(v), 32'(exp_read(model_ptr)));
            model_ptr = exp_next(model_ptr);
        end
        bus_stop();
        tick(4);
    endtask

    initial begin
        logic ack;
        logic [7:0] v;
        logic b;
        void'($urandom(32'h1C3E));
        for (int i = 0; i < NREG; i++) model_reg[i] = 8'h00;
        model_ptr = 8'h00;
        ro_data = 48'hA5_96_87_78_69_5A;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R11: reset state
        check("R11", "sda released after reset", 32'(sda_pull), 32'd0);
        check_bank("R11");
        do_read("R11", 1'b0, 8'h00, 1);

        // R4 R7: masked writes to 0..2
        wbuf[0] = 8'hFF; wbuf[1] = 8'hFF; wbuf[2] = 8'hFF;
        do_write("R7", 8'h00, 3);
        check("R7", "reg1 masked", 32'(bank[15:8]), 32'hE0);
        wbuf[0] = 8'h5C;
        do_write("R4", 8'h00, 1);

        // R5 R7: from 9 the pointer loops to 3, read-only writes dropped
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        do_write("R5", 8'h09, 3);
        check("R5", "reg9 written", 32'(bank[79:72]), 32'h11);

        // R1 R5: burst read over the loop
        do_read("R5", 1'b1, 8'h07, 6);

        // R5: from 12 the pointer wraps to 0
        wbuf[0] = 8'hC3; wbuf[1] = 8'h3A;
        do_write("R5", 8'h0C, 2);
        check("R5", "reg0 after wrap", 32'(bank[7:0]), 32'h3A);

        // R6: invalid write dropped, pointer above top goes to 0
        wbuf[0] = 8'h77; wbuf[1] = 8'h81;
        do_write("R6", 8'h20, 2);
        check("R6", "reg0 after invalid", 32'(bank[7:0]), 32'h81);

        // R6: invalid read returns zero, then wraps
        do_read("R6", 1'b1, 8'h0D, 2);
        do_read("R6", 1'b1, 8'hF0, 1);

        // R2: wrong address is ignored
        bus_start();
        send_byte(8'h50, ack);
        check("R2", "wrong address nack", 32'(ack), 32'd0);
        send_byte(8'h00, ack);
        check("R2", "byte after wrong address", 32'(ack), 32'd0);
        send_byte(8'hAA, ack);
        check("R2", "byte after wrong address", 32'(ack), 32'd0);
        bus_stop();
        tick(4);
        check_bank("R2");
        bus_start();
        send_byte(8'h3F, ack);
        check("R2", "wrong read address nack", 32'(ack), 32'd0);
        bus_stop();

        // R8 R10: master NACK ends read, bus stays released, STOP keeps pointer
        bus_start();
        send_byte(8'h3C, ack);
        send_byte(8'h00, ack);
        model_ptr = 8'h00;
        bus_start();
        send_byte(8'h3D, ack);
        check("R8", "read address ack", 32'(ack), 32'd1);
        for (int i = 0; i < 2; i++) begin
            recv_byte(i == 0, v);
            check("R8", "read byte", 32'(v), 32'(exp_read(model_ptr)));
            model_ptr = exp_next(model_ptr);
        end
        for (int i = 0; i < 8; i++) begin
            get_bit(b);
            check("R8", "line released after nack", 32'(b), 32'd1);
        end
        put_bit(1'b1);
        bus_stop();
        tick(4);
        ro_data = 48'h12_34_56_78_9A_BC;
        do_read("R10", 1'b0, 8'h00, 3);

        // randomized writes and read-backs
        for (int it = 0; it < 18; it++) begin
            int n;
            logic [7:0] p;
            n = 1 + int'($urandom % 4);
            p = 8'($urandom % 16);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            do_write("R4", p, n);
            if (it % 3 == 0) ro_data = {$urandom, 16'($urandom)};
            n = 1 + int'($urandom % 5);
            p = 8'($urandom % 16);
            do_read("R5", 1'b1, p, n);
        end

        check("R9", "pull changes while SCL high", 32'(r9_viol), 32'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule